// File: doc/BRIEF.md
# Recycling Integrator Discharge Pulse Generator

This block drives the reset side of a charge-integrating current-to-frequency converter. An external comparator watches the integration capacitor and raises its output when the capacitor is full. The block then produces a single discharge pulse of fixed length. Through an external resistor, that pulse pulls a constant charge packet of about 1.63 pC off the capacitor. Because every pulse removes the same charge, the pulse rate is proportional to the input current. Sustained rates reach roughly 700 kHz.

Two outputs report each event. The timing output is meant for a time-to-digital converter that measures the interval between pulses. It is the raw comparator level ORed with the discharge drive, so its rising edge follows the comparator edge with no clock quantisation. A saturating pulse counter accumulates total charge, and therefore dose. One count equals one packet. As an example, 128 counts at full-scale current give a 7-bit reading. The clocked control path sees the comparator only through a synchronizer. A pulse in progress cannot be restarted. The pulse length is a parameter: the default of 60 cycles gives 1.2 µs at a 50 MHz clock.

Top module: `discharge_pulse_gen`

## Requirements
- R1: After reset is released, discharge_o and timing_o are 0 and pulse_count_o is 0 while disc_i stays low.
- R2: When disc_i rises while no pulse is active, discharge_o goes high at the (SYNC_STAGES+1)-th rising clock edge after the change, which is the third edge with the default of 2.
- R3: Every discharge pulse is high for exactly WIDTH_CYC consecutive clock cycles (default 60).
- R4: A disc_i high that occurs during an active pulse and returns low at least SYNC_STAGES+1 cycles before the pulse ends starts no further pulse and does not change pulse_count_o.
- R5: If disc_i is still high when a pulse ends, the next pulse starts after exactly one low cycle of discharge_o.
- R6: timing_o is the OR of disc_i and discharge_o with no clocked delay: a rising disc_i shows on timing_o before any clock edge.
- R7: pulse_count_o increases by exactly one at the clock edge where discharge_o rises and changes at no other time unless it is cleared.
- R8: pulse_count_o saturates at all ones (2^CNT_W - 1) and holds that value as further pulses occur.
- R9: A high cnt_clr_i sampled at a clock edge makes pulse_count_o zero at that edge. A clear wins over an increment at the same edge, so a pulse starting at that edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| disc_i | input | 1 | Raw comparator level, high when the integration capacitor is full |
| cnt_clr_i | input | 1 | Synchronous clear of the pulse counter |
| discharge_o | output | 1 | Fixed-width charge-removal drive |
| timing_o | output | 1 | Event output for interval timing; rising edge follows disc_i directly |
| pulse_count_o | output | CNT_W | Saturating count of discharge pulses |

## Verification
Isolated comparator events establish the start latency and the exact pulse width. Short comparator events inside a running pulse separate a non-retriggerable generator from one that restarts or queues the event. Holding the comparator high across several pulses shows level re-arming with its single low cycle. A clear that lands on a pulse-start edge settles clear priority, and a long run of pulses with a narrow counter reaches saturation. Dense random comparator activity mixed with random clears is compared cycle by cycle against a bench model, which catches off-by-one errors in the timer and the counter.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FIRE = 1'b1
  } dpg_state_e;

  function automatic int unsigned tmr_bits(input int unsigned cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction

endpackage

// File: rtl/dpg_sync.sv
module dpg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dpg_pulse_fsm.sv
module dpg_pulse_fsm
  import dpg_pkg::*;
#(
  parameter int unsigned WIDTH_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic fire_o,
  output logic start_o
);

  localparam int unsigned TW = tmr_bits(WIDTH_CYC);
  localparam logic [TW-1:0] TMR_LOAD = TW'(WIDTH_CYC - 1);

  dpg_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic          start;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          state_d = ST_FIRE;
          tmr_d   = TMR_LOAD;
          start   = 1'b1;
        end
      end
      ST_FIRE: begin
        if (tmr_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_en = start | (state_q == ST_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign fire_o  = (state_q == ST_FIRE);
  assign start_o = start;

endmodule

// File: rtl/dpg_sat_counter.sv
module dpg_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;
  logic             cnt_en;

  assign at_max = &cnt_q;
  assign cnt_en = clr_i | (inc_i & ~at_max);

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/discharge_pulse_gen.sv
module discharge_pulse_gen #(
  parameter int unsigned WIDTH_CYC   = 60,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disc_i,
  input  logic             cnt_clr_i,
  output logic             discharge_o,
  output logic             timing_o,
  output logic [CNT_W-1:0] pulse_count_o
);

  logic rst_n_int;
  logic disc_s;
  logic fire;
  logic start;

  // Reset: asserted at once, released after two clock edges.
  dpg_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (1'b1),
    .q_o  (rst_n_int)
  );

  // The comparator level is asynchronous to clk.
  dpg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_disc_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  (disc_i),
    .q_o  (disc_s)
  );

  dpg_pulse_fsm #(.WIDTH_CYC(WIDTH_CYC)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .trig_i (disc_s),
    .fire_o (fire),
    .start_o(start)
  );

  dpg_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n_int),
    .inc_i(start),
    .clr_i(cnt_clr_i),
    .cnt_o(pulse_count_o)
  );

  assign discharge_o = fire;
  // The raw comparator level bypasses the synchronizer so that the
  // rising edge carries no clock quantisation.
  assign timing_o    = disc_i | fire;

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int unsigned WIDTH_CYC = 60,
  parameter int unsigned CNT_W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disc_i,
  input logic             cnt_clr_i,
  input logic             discharge_o,
  input logic             timing_o,
  input logic [CNT_W-1:0] pulse_count_o
);

  localparam int unsigned RW = $clog2(WIDTH_CYC + 2) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (discharge_o) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discharge_o) |-> (run_q == RW'(WIDTH_CYC)));

  assert_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    discharge_o |-> (run_q < RW'(WIDTH_CYC)));

  assert_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_i || discharge_o) |-> timing_o);

  assert_count_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(discharge_o) && !$past(cnt_clr_i) && ($past(pulse_count_o) != {CNT_W{1'b1}}))
      |-> (pulse_count_o == CNT_W'($past(pulse_count_o) + 1'b1)));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(discharge_o) && !$past(cnt_clr_i)) |-> $stable(pulse_count_o));

  assert_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pulse_count_o) == {CNT_W{1'b1}}) && !$past(cnt_clr_i))
      |-> (pulse_count_o == {CNT_W{1'b1}}));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr_i) |-> (pulse_count_o == '0));

endmodule

bind discharge_pulse_gen dpg_checker #(
  .WIDTH_CYC(WIDTH_CYC),
  .CNT_W    (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .disc_i       (disc_i),
  .cnt_clr_i    (cnt_clr_i),
  .discharge_o  (discharge_o),
  .timing_o     (timing_o),
  .pulse_count_o(pulse_count_o)
);

// File: tb/discharge_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module discharge_pulse_gen_tb_top;

  localparam int unsigned W     = 60;
  localparam int unsigned CW    = 6;
  localparam int unsigned SYNC  = 2;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          clk;
  logic          rst_n;
  logic          disc;
  logic          clr;
  logic          discharge;
  logic          timing;
  logic [CW-1:0] count;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  discharge_pulse_gen #(.WIDTH_CYC(W), .CNT_W(CW), .SYNC_STAGES(SYNC)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .disc_i       (disc),
    .cnt_clr_i    (clr),
    .discharge_o  (discharge),
    .timing_o     (timing),
    .pulse_count_o(count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic cl, input logic st);
    if (cl) return '0;
    if (st && (c != CMAX)) return c + 1'b1;
    return c;
  endfunction

  function automatic int start_latency(input int stages);
    return stages + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  logic          rr1, rr2, d1, d2, m_hi;
  int            m_rem;
  logic [CW-1:0] m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr1 <= 0; rr2 <= 0; d1 <= 0; d2 <= 0; m_hi <= 0; m_rem <= 0; m_cnt <= '0;
    end else begin
      rr1 <= 1'b1;
      rr2 <= rr1;
      if (rr2) begin
        d1 <= disc;
        d2 <= d1;
        if (m_hi) begin
          if (m_rem == 0) m_hi <= 1'b0;
          else m_rem <= m_rem - 1;
        end else if (d2) begin
          m_hi  <= 1'b1;
          m_rem <= W - 1;
        end
        m_cnt <= next_count(m_cnt, clr, !m_hi && d2);
      end
    end
  end

  // Pulse and gap length monitor, plus cycle-by-cycle comparison
  int run_hi = 0, run_lo = 0, last_w = 0, last_gap = 0;
  bit seen_pulse = 1'b0;

  always @(negedge clk) begin
    if (rst_n && rr2) begin
      check(discharge == m_hi, "R3", "discharge_o vs model", discharge, m_hi);
      check(count == m_cnt, "R7", "pulse_count_o vs model", count, m_cnt);
    end
    if (discharge) begin
      if (run_hi == 0 && seen_pulse) last_gap = run_lo;
      run_hi++;
      run_lo = 0;
      seen_pulse = 1'b1;
    end else begin
      if (run_hi > 0) last_w = run_hi;
      run_hi = 0;
      run_lo++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c0;
    int lat;
    void'($urandom(32'd20110610));
    rst_n = 1'b0; disc = 1'b0; clr = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1
    check(discharge == 1'b0, "R1", "discharge_o after reset", discharge, 0);
    check(timing == 1'b0, "R1", "timing_o after reset", timing, 0);
    check(count == '0, "R1", "pulse_count_o after reset", count, 0);

    // R6: combinational path, no clock edge in between
    disc = 1'b1;
    #1;
    check(timing == 1'b1, "R6", "timing_o follows disc_i before an edge", timing, 1);
    check(discharge == 1'b0, "R6", "discharge_o not yet high", discharge, 0);

    // R2: latency from disc_i rise to discharge_o rise
    lat = 0;
    while (!discharge && lat < 10) begin
      tick(1);
      lat++;
    end
    check(lat == start_latency(SYNC), "R2", "edges to discharge rise", lat, start_latency(SYNC));
    check(count == 1, "R7", "count after first pulse", count, 1);
    tick(3);
    disc = 1'b0;

    // R4: event inside the pulse is ignored
    tick(20);
    disc = 1'b1;
    tick(8);
    disc = 1'b0;
    c0 = count;
    tick(W);
    check(discharge == 1'b0, "R4", "no retrigger after pulse", discharge, 0);
    check(count == c0, "R4", "count unchanged by ignored event", count, c0);
    check(last_w == W, "R3", "isolated pulse width", last_w, W);

    // R5: level held across pulse end
    disc = 1'b1;
    tick(3 * (W + 1) + 5);
    disc = 1'b0;
    check(last_gap == 1, "R5", "low cycles between back-to-back pulses", last_gap, 1);
    check(last_w == W, "R3", "back-to-back pulse width", last_w, W);
    tick(W + 5);
    check(timing == 1'b0, "R6", "timing_o low when idle", timing, 0);

    // R9: plain clear
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check(count == '0, "R9", "count after clear", count, 0);

    // R9: clear on the pulse-start edge wins
    disc = 1'b1;
    tick(start_latency(SYNC) - 1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check(discharge == 1'b1, "R9", "pulse started at clear edge", discharge, 1);
    check(count == '0, "R9", "clear wins over increment", count, 0);
    disc = 1'b0;
    tick(W + 5);

    // R8: saturation
    disc = 1'b1;
    tick((int'(CMAX) + 4) * (W + 1));
    check(count == CMAX, "R8", "count saturates", count, CMAX);
    tick(2 * (W + 1));
    check(count == CMAX, "R8", "count holds at max", count, CMAX);
    disc = 1'b0;
    tick(W + 5);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check(count == '0, "R9", "clear from saturation", count, 0);

    // Random activity, compared against the model every cycle (R3, R4, R5, R7, R9)
    for (int s = 0; s < 400; s++) begin
      disc = ($urandom_range(0, 1) == 1);
      for (int k = 0; k < int'($urandom_range(1, 120)); k++) begin
        clr = ($urandom_range(0, 99) == 0);
        tick(1);
      end
      clr = 1'b0;
    end
    disc = 1'b0;
    tick(W + 5);
    check(discharge == 1'b0, "R3", "idle after random phase", discharge, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule